// File: doc/BRIEF.md
# Filter-Chain Program Sequencer

This block is a small microcoded controller that steps through a 32-entry instruction store and drives a shared filter compute engine. Each 21-bit instruction is one of three classes. A WAIT stalls until a condition holds. A FIR launches a filter pass and applies control side effects. A JUMP branches when its condition holds. The sequencer keeps a loadable 12-bit loop counter and a wait counter. The wait counter is raised by an external event input and compared against a 10-bit threshold. It also holds a two-bit up-conversion phase counter that rotates the data multiplier through 1, j, -1 and -j.

A host write port fills the instruction store and the threshold. The engine answers each start pulse with a done pulse, and the sequencer waits for that pulse before it moves on. Dropping the run input sends the sequencer back to step 0.

The controller has three named states. IDLE holds the program counter at 0. EXEC decodes and executes the instruction at the program counter, one cycle per instruction. BUSY waits for the engine. The transitions are:
- IDLE→EXEC when run is high.
- EXEC→EXEC for a WAIT, a JUMP, or a FIR without the start bit.
- EXEC→BUSY for a FIR with the start bit.
- BUSY→EXEC when done arrives.
- Any state→IDLE when run is low.

Top module: `fir_seq_ctrl`

## Requirements
- R1: Bit 8 set decodes as JUMP. Bits 8:7 = 00 decode as WAIT. Bits 8:7 = 01 decode as FIR.
- R2: A JUMP loads the program counter from bits 7:3 when the condition in bits 2:0 holds. Otherwise it advances the program counter by one.
- R3: A WAIT holds the program counter until its condition in bits 2:0 holds, then advances it by one.
- R4: A FIR with bit 6 set does four things. It gives a start pulse exactly one cycle long. It holds the type code (bits 14:9), the step count (bits 17:15), resampler increment (bit 5) and up-conversion enable (bit 0) through the filter pass. It leaves the program counter unchanged until done. The program counter advances on the edge that samples done.
- R5: A FIR with bit 6 clear takes one cycle, gives no start pulse and advances the program counter by one.
- R6: FIR bit 2 loads the loop counter from bits 20:9. FIR bit 1 decrements the loop counter, saturating at 0. Condition 010 means the loop counter is nonzero, and 011 means it is zero.
- R7: Each cycle with wait_inc high adds one to the wait counter. FIR bit 3 pulses wait_dec and subtracts 1 from the wait counter, or 2 when bit 4 is set, saturating at 0. Condition 000 means wait count < threshold, and 001 means wait count >= threshold.
- R8: Condition 100 means the NCO carry is clear, 101 means the NCO carry is set, 110 means the sync bit is set, and 111 means always.
- R9: The up-conversion phase (0=1, 1=j, 2=-1, 3=-j) advances by one modulo 4 in one of two places. With uc_at_output low, it advances on the start of a FIR that has bit 0 set. With uc_at_output high, it advances on done from such a filter.
- R10: In reset, or with run low, the program counter is 0 and no start pulse is given. The phase resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Run enable; low forces step 0 |
| prog_we | input | 1 | Instruction store write strobe |
| prog_addr | input | 5 | Instruction store write address |
| prog_data | input | 21 | Instruction word |
| thr_we | input | 1 | Threshold write strobe |
| thr_data | input | 10 | Wait threshold |
| nco_carry | input | 1 | Resampler NCO carry |
| sync_bit | input | 1 | Sync or host-controlled condition bit |
| wait_inc | input | 1 | Wait counter increment event |
| eng_done | input | 1 | Filter engine completion |
| uc_at_output | input | 1 | Phase advance point: 0 at start, 1 at done |
| pc | output | 5 | Current program step |
| eng_start | output | 1 | One-cycle filter start pulse |
| fir_type | output | 6 | Filter type code of the current pass |
| fir_steps | output | 3 | Steps per pass minus one |
| rs_inc | output | 1 | Resampler increment during pass |
| wait_dec | output | 1 | Wait decrement pulse |
| uc_en | output | 1 | Up-conversion enable during pass |
| uc_phase | output | 2 | Rotation phase (0=1, 1=j, 2=-1, 3=-j) |

## Verification
A bad loop or wait counter cannot be read directly. It shows up at the ports as a wrong program step. A conditional jump or WAIT that reads the bad value branches or releases on the wrong cycle, which is visible on pc within one instruction of the test. Saturation faults are aimed at directly: a decrement from zero that wraps makes a "zero" jump fall through. A wrong FSM state shows as a start pulse that lasts too long or repeats, or as pc moving before done. A wrong phase shows as a skipped or early step of uc_phase on the cycle after start or done.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
    localparam int INSTR_W = 21;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EXEC = 2'd1,
        S_BUSY = 2'd2
    } fsq_state_e;

    typedef enum logic [2:0] {
        CC_WAIT_LT   = 3'd0,
        CC_WAIT_GE   = 3'd1,
        CC_LOOP_NZ   = 3'd2,
        CC_LOOP_Z    = 3'd3,
        CC_CARRY_CLR = 3'd4,
        CC_CARRY_SET = 3'd5,
        CC_SYNC      = 3'd6,
        CC_ALWAYS    = 3'd7
    } fsq_cc_e;
endpackage

// File: rtl/fsq_cond.sv
module fsq_cond
    import fsq_pkg::*;
(
    input  logic [2:0] cc,
    input  logic       wait_ge,
    input  logic       loop_zero,
    input  logic       nco_carry,
    input  logic       sync_bit,
    output logic       hit
);
    always_comb begin
        unique case (fsq_cc_e'(cc))
            CC_WAIT_LT:   hit = !wait_ge;
            CC_WAIT_GE:   hit = wait_ge;
            CC_LOOP_NZ:   hit = !loop_zero;
            CC_LOOP_Z:    hit = loop_zero;
            CC_CARRY_CLR: hit = !nco_carry;
            CC_CARRY_SET: hit = nco_carry;
            CC_SYNC:      hit = sync_bit;
            CC_ALWAYS:    hit = 1'b1;
            default:      hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/fsq_counters.sv
module fsq_counters #(
    parameter int LOOP_W = 12,
    parameter int WAIT_W = 10,
    parameter int DEC_LO = 1,
    parameter int DEC_HI = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_loop,
    input  logic [LOOP_W-1:0] ld_val,
    input  logic              dec_loop,
    input  logic              wait_inc,
    input  logic              wait_dec,
    input  logic              dec_sel,
    input  logic [WAIT_W-1:0] thr,
    output logic              loop_zero,
    output logic              wait_ge
);
    localparam logic [WAIT_W:0] WMAX = {1'b0, {WAIT_W{1'b1}}};
    localparam logic [WAIT_W:0] AMT_LO = (WAIT_W+1)'(DEC_LO);
    localparam logic [WAIT_W:0] AMT_HI = (WAIT_W+1)'(DEC_HI);

    logic [LOOP_W-1:0] loop_q;
    logic [WAIT_W-1:0] wait_q;
    logic [WAIT_W:0]   sum;
    logic [WAIT_W:0]   amt;
    logic [WAIT_W:0]   wnext;

    always_comb begin
        sum = {1'b0, wait_q} + {{WAIT_W{1'b0}}, wait_inc};
        if (sum > WMAX) sum = WMAX;
        amt = dec_sel ? AMT_HI : AMT_LO;
        if (!wait_dec) wnext = sum;
        else if (sum < amt) wnext = '0;
        else wnext = sum - amt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loop_q <= '0;
            wait_q <= '0;
        end else begin
            if (ld_loop) loop_q <= ld_val;
            else if (dec_loop && loop_q != '0) loop_q <= loop_q - 1'b1;
            wait_q <= wnext[WAIT_W-1:0];
        end
    end

    assign loop_zero = (loop_q == '0);
    assign wait_ge   = (wait_q >= thr);

    // R6: a decrement at zero keeps the loop counter at zero
    a_r6_loop_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_loop && !ld_loop && loop_q == '0) |=> loop_q == '0);

    // R7: a decrement never raises the wait count
    a_r7_wait_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_dec && !wait_inc) |=> wait_q <= $past(wait_q));
endmodule

// File: rtl/fsq_rot.sv
module fsq_rot #(
    parameter int PH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            adv,
    output logic [PH_W-1:0] phase
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= '0;
        else if (clr) phase <= '0;
        else if (adv) phase <= phase + 1'b1;
    end

    // R9: the phase only ever moves forward by one step
    a_r9_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(phase) && phase != '0) |-> phase == $past(phase) + 1'b1);
endmodule

// File: rtl/fir_seq_ctrl.sv
module fir_seq_ctrl
    import fsq_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int THR_W  = 10,
    parameter int LOOP_W = 12,
    localparam int PC_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               prog_we,
    input  logic [PC_W-1:0]    prog_addr,
    input  logic [INSTR_W-1:0] prog_data,
    input  logic               thr_we,
    input  logic [THR_W-1:0]   thr_data,
    input  logic               nco_carry,
    input  logic               sync_bit,
    input  logic               wait_inc,
    input  logic               eng_done,
    input  logic               uc_at_output,
    output logic [PC_W-1:0]    pc,
    output logic               eng_start,
    output logic [5:0]         fir_type,
    output logic [2:0]         fir_steps,
    output logic               rs_inc,
    output logic               wait_dec,
    output logic               uc_en,
    output logic [1:0]         uc_phase
);
    logic [INSTR_W-1:0] store [DEPTH];
    logic [THR_W-1:0]   thr_q;
    fsq_state_e         state;
    logic [PC_W-1:0]    pc_q;
    logic [INSTR_W-1:0] ins;
    logic               is_jump, is_wait, is_fir, in_exec, fir_go, start_go;
    logic               hit, loop_zero, wait_ge, done_go, rot_adv;
    logic [5:0]         type_q;
    logic [2:0]         steps_q;
    logic               rs_q, uc_q;

    always_ff @(posedge clk) begin
        if (prog_we) store[prog_addr] <= prog_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) thr_q <= '0;
        else if (thr_we) thr_q <= thr_data;
    end

    assign ins      = store[pc_q];
    assign is_jump  = ins[8];
    assign is_wait  = !ins[8] && !ins[7];
    assign is_fir   = !ins[8] && ins[7];
    assign in_exec  = run && (state == S_EXEC);
    assign fir_go   = in_exec && is_fir;
    assign start_go = fir_go && ins[6];
    assign done_go  = run && (state == S_BUSY) && eng_done;

    fsq_cond u_cond (
        .cc        (ins[2:0]),
        .wait_ge   (wait_ge),
        .loop_zero (loop_zero),
        .nco_carry (nco_carry),
        .sync_bit  (sync_bit),
        .hit       (hit)
    );

    fsq_counters #(
        .LOOP_W (LOOP_W),
        .WAIT_W (THR_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_loop   (fir_go && ins[2]),
        .ld_val    (ins[20:9]),
        .dec_loop  (fir_go && ins[1]),
        .wait_inc  (wait_inc),
        .wait_dec  (wait_dec),
        .dec_sel   (ins[4]),
        .thr       (thr_q),
        .loop_zero (loop_zero),
        .wait_ge   (wait_ge)
    );

    assign rot_adv = uc_at_output ? (done_go && uc_q) : (start_go && ins[0]);

    fsq_rot u_rot (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .adv   (rot_adv),
        .phase (uc_phase)
    );

    // State register and program counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            pc_q  <= '0;
        end else if (!run) begin
            state <= S_IDLE;
            pc_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    state <= S_EXEC;
                    pc_q  <= '0;
                end
                S_EXEC: begin
                    if (is_jump) begin
                        pc_q <= hit ? ins[7:3] : pc_q + 1'b1;
                    end else if (is_wait) begin
                        if (hit) pc_q <= pc_q + 1'b1;
                    end else if (ins[6]) begin
                        state <= S_BUSY;
                    end else begin
                        pc_q <= pc_q + 1'b1;
                    end
                end
                S_BUSY: begin
                    if (eng_done) begin
                        state <= S_EXEC;
                        pc_q  <= pc_q + 1'b1;
                    end
                end
                default: begin
                    state <= S_IDLE;
                    pc_q  <= '0;
                end
            endcase
        end
    end

    // Filter-pass outputs held from start until done
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_q  <= '0;
            steps_q <= '0;
            rs_q    <= 1'b0;
            uc_q    <= 1'b0;
        end else if (!run || done_go) begin
            rs_q <= 1'b0;
            uc_q <= 1'b0;
        end else if (start_go) begin
            type_q  <= ins[14:9];
            steps_q <= ins[17:15];
            rs_q    <= ins[5];
            uc_q    <= ins[0];
        end
    end

    assign pc        = pc_q;
    assign eng_start = start_go;
    assign wait_dec  = fir_go && ins[3];
    assign fir_type  = type_q;
    assign fir_steps = steps_q;
    assign rs_inc    = rs_q;
    assign uc_en     = uc_q;

    // R4: start lasts one cycle and is followed by the busy state
    a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && run) |=> (!eng_start && (state == S_BUSY || !run)));

    // R4: program counter stays put while the engine is busy
    a_r4_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY && run && !eng_done) |=> pc == $past(pc));

    // R3: an unmet WAIT holds the step
    a_r3_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && is_wait && !hit) |=> (pc == $past(pc) || !run));

    // R10: run low returns to step 0 with no start
    a_r10_idle_pc: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pc == '0 && !eng_start));
endmodule

// File: tb/sim_fir_seq_ctrl.sv
module sim_fir_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n, run, prog_we, thr_we, nco_carry, sync_bit, wait_inc, eng_done, uc_at_output;
    logic [4:0]  prog_addr;
    logic [20:0] prog_data;
    logic [9:0]  thr_data;
    logic [4:0]  pc;
    logic        eng_start, rs_inc, wait_dec, uc_en;
    logic [5:0]  fir_type;
    logic [2:0]  fir_steps;
    logic [1:0]  uc_phase;
    int          checks = 0;
    int          errors = 0;

    localparam int C_START = 64, C_RS = 32, C_SEL = 16, C_WDEC = 8, C_LD = 4, C_LDEC = 2, C_UC = 1;

    always #10 clk = ~clk;

    fir_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .thr_we(thr_we), .thr_data(thr_data), .nco_carry(nco_carry),
        .sync_bit(sync_bit), .wait_inc(wait_inc), .eng_done(eng_done), .uc_at_output(uc_at_output),
        .pc(pc), .eng_start(eng_start), .fir_type(fir_type), .fir_steps(fir_steps),
        .rs_inc(rs_inc), .wait_dec(wait_dec), .uc_en(uc_en), .uc_phase(uc_phase)
    );

    function automatic logic [20:0] f_jump(int dest, int cc);
        return 21'((1 << 8) | (dest << 3) | cc);
    endfunction
    function automatic logic [20:0] f_wait(int cc);
        return 21'(cc);
    endfunction
    function automatic logic [20:0] f_fir(int steps, int typ, int ctl);
        return 21'((steps << 15) | (typ << 9) | (1 << 7) | ctl);
    endfunction
    function automatic logic [20:0] f_ldlp(int v);
        return 21'((v << 9) | (1 << 7) | C_LD);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run = 1'b0; prog_we = 1'b0; thr_we = 1'b0; nco_carry = 1'b0;
        sync_bit = 1'b0; wait_inc = 1'b0; eng_done = 1'b0; uc_at_output = 1'b0;
        prog_addr = '0; prog_data = '0; thr_data = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wr(input int a, input logic [20:0] d);
        prog_we = 1'b1; prog_addr = 5'(a); prog_data = d;
        tick();
        prog_we = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R10 reset pc", pc, 0);
        chk("R10 reset start", eng_start, 0);
        chk("R10 reset phase", uc_phase, 0);
    endtask

    task automatic t_fir_start();
        do_reset();
        wr(0, f_fir(0, 5, C_START | C_RS));
        wr(1, f_jump(1, 7));
        run = 1'b1;
        tick();
        chk("R4 start pulse", eng_start, 1);
        tick();
        chk("R4 start one cycle", eng_start, 0);
        chk("R4 type held", fir_type, 5);
        chk("R4 rs_inc held", rs_inc, 1);
        chk("R1 FIR decode pc held", pc, 0);
        tick(); tick();
        chk("R4 pc waits for done", pc, 0);
        eng_done = 1'b1;
        tick();
        eng_done = 1'b0;
        chk("R4 pc after done", pc, 1);
        chk("R4 rs_inc cleared", rs_inc, 0);
        tick();
        chk("R2 jump always self", pc, 1);
        chk("R1 no start on jump", eng_start, 0);
    endtask

    task automatic t_loop();
        do_reset();
        wr(0, f_ldlp(3));
        wr(1, f_fir(0, 0, C_LDEC));
        wr(2, f_jump(1, 2));
        wr(3, f_fir(0, 0, C_LDEC));
        wr(4, f_jump(6, 3));
        wr(5, f_jump(5, 7));
        wr(6, f_jump(6, 7));
        run = 1'b1;
        for (int i = 0; i < 7; i++) begin
            tick();
            check(eng_start == 0, "R5 no start in loop", eng_start, 0);
        end
        chk("R6 loop still running", pc, 2);
        tick();
        chk("R6 loop exits on zero", pc, 3);
        tick(); tick();
        chk("R6 decrement saturates at zero", pc, 6);
    endtask

    task automatic t_wait();
        do_reset();
        thr_we = 1'b1; thr_data = 10'd2;
        tick();
        thr_we = 1'b0;
        wr(0, f_wait(6));
        wr(1, f_fir(0, 0, C_WDEC | C_SEL));
        wr(2, f_wait(0));
        wr(3, f_fir(0, 0, C_WDEC | C_SEL));
        wr(4, f_wait(1));
        run = 1'b1;
        tick();
        wait_inc = 1'b1;
        tick(); tick(); tick();
        wait_inc = 1'b0;
        sync_bit = 1'b1;
        chk("R3 wait holds on false sync", pc, 0);
        tick();
        sync_bit = 1'b0;
        chk("R8 sync releases wait", pc, 1);
        chk("R7 wait_dec pulse", wait_dec, 1);
        tick(); tick();
        chk("R7 decrement by two below threshold", pc, 3);
        tick();
        chk("R7 reaches second wait", pc, 4);
        for (int i = 0; i < 4; i++) tick();
        chk("R7 wait count saturates at zero", pc, 4);
        run = 1'b0;
        tick();
        chk("R10 run low restarts", pc, 0);
        chk("R10 no start when idle", eng_start, 0);
    endtask

    task automatic t_rot_start();
        do_reset();
        nco_carry = 1'b1;
        wr(0, f_jump(2, 5));
        wr(1, f_jump(1, 7));
        wr(2, f_fir(1, 32, C_START | C_UC));
        wr(3, f_jump(2, 7));
        run = 1'b1;
        tick(); tick();
        chk("R8 carry set jump taken", pc, 2);
        chk("R4 complex start", eng_start, 1);
        tick();
        chk("R9 phase after start", uc_phase, 1);
        chk("R4 complex type", fir_type, 32);
        chk("R4 complex steps", fir_steps, 1);
        chk("R4 uc_en held", uc_en, 1);
        eng_done = 1'b1;
        for (int k = 2; k <= 4; k++) begin
            tick();
            eng_done = 1'b0;
            tick();
            chk("R9 restart", eng_start, 1);
            tick();
            chk("R9 phase rotation", uc_phase, k % 4);
            eng_done = 1'b1;
        end
        tick();
        eng_done = 1'b0;
    endtask

    task automatic t_rot_output();
        do_reset();
        uc_at_output = 1'b1;
        wr(0, f_fir(0, 1, C_START | C_UC));
        wr(1, f_jump(1, 7));
        run = 1'b1;
        tick(); tick();
        chk("R9 output mode no advance at start", uc_phase, 0);
        eng_done = 1'b1;
        tick();
        eng_done = 1'b0;
        chk("R9 output mode advance at done", uc_phase, 1);
        chk("R4 uc_en cleared", uc_en, 0);
    endtask

    task automatic t_carry_clear();
        do_reset();
        wr(0, f_jump(5, 4));
        wr(1, f_jump(1, 7));
        wr(5, f_jump(5, 7));
        run = 1'b1;
        tick(); tick();
        chk("R8 carry clear jump taken", pc, 5);
        do_reset();
        nco_carry = 1'b1;
        run = 1'b1;
        tick(); tick();
        chk("R2 false jump falls through", pc, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_fir_start();
        t_loop();
        t_wait();
        t_rot_start();
        t_rot_output();
        t_carry_clear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule